// File: doc/BRIEF.md
# Multi-Rail Power Sequencer

This controller brings up a group of supply rails in a fixed order and takes them down again. Software sets one enable bit through a small byte-wide register port. The block then switches on rail 0 and waits for that rail's power-good input. It moves on to rail 1 only after that power-good is seen, and it carries on the same way up to the last rail. Each step has its own time limit. If a power-good does not arrive within that limit, the block sets an alarm, records which rail failed, and drops every rail at once.

When software clears the enable bit, the rails are switched off in reverse order, one per clock. The sequencer then stays in a discharge hold for a fixed number of cycles before it acts on any new enable. Because of this hold, a quick off-on toggle always restarts a clean bring-up from rail 0 with a fresh time limit. It can never stall waiting for power-goods left over from a rail that has not yet decayed. While the rails are fully up, losing any power-good is also treated as a fault. Alarm and fail bits stay set until software clears the enable.

Top module: `rail_sequencer`

## Requirements
- R1: After reset all rail enables are low, the control bit reads 0, the timeout register reads TMO_RESET, and the status and fail registers read 0.
- R2: With enable set, the rails are enabled one at a time in the order 0, 1, 2, 3. Rail k+1 is switched on at the clock edge that samples power-good k high. Enabled rails always form a contiguous group starting at rail 0.
- R3: The status register at address 0xA holds the live power-good inputs in bits 3:0, the alarm in bit 4, and zeros above. A fully powered, fault-free block reads exactly 0x0F.
- R4: If power-good k is still low at the edge that ends cycle number max(T*STEP_UNIT,1) of step k (T is the timeout register), then at that edge the alarm is set, the fail register becomes the one-hot value with bit k set, and all rail enables drop.
- R5: Alarm and fail stay latched for as long as the enable bit is 1. Both clear at the first edge that sees the enable at 0.
- R6: Clearing the enable turns the enabled rails off one per clock, the highest-numbered rail first.
- R7: After the last rail goes off, or after a fault is cleared, the block waits HOLD_CYC cycles before starting again. An enable written during the down-ramp or the hold is acted on afterwards, and bring-up restarts from rail 0.
- R8: With all rails up and enable set, any power-good going low raises the alarm, sets the fail register to the mask of the missing rails, and drops all rails.
- R9: Register map: version at 0x0 (reads VERSION), control at 0x6 (bit 0 is the enable), timeout at 0x8 (read/write), status at 0xA, fail at 0xB. Writes to version, status and fail have no effect, and unmapped addresses read 0.
- R10: Clearing the enable during bring-up stops the ramp and turns off the rails already enabled, in reverse order, with no alarm.
- R11: A timeout value of 0 faults at the first edge of a step whose power-good is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, captured on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pg_in | input | NRAIL | Per-rail power-good inputs |
| rail_en | output | NRAIL | Per-rail supply enables |

## Verification
The bench builds the block with STEP_UNIT=4, HOLD_CYC=20 and a reset timeout of 10. With these values the per-step limit is 40 cycles and the discharge hold is 20 cycles. Timeouts, hold expiry and quick enable toggles therefore all happen within a few hundred cycles. Modelled regulators with per-rail rise delays, a decay delay, a dead-rail switch and a dropout switch cover the normal ramp, a mid-ramp abort, a step timeout, a zero timeout, and power loss while fully up.

// File: rtl/rail_sequencer.sv
module rail_sequencer #(
  parameter int          NRAIL     = 4,
  parameter int          STEP_UNIT = 1024,
  parameter int          HOLD_CYC  = 4096,
  parameter logic [7:0]  TMO_RESET = 8'd200,
  parameter logic [7:0]  VERSION   = 8'h03,
  parameter int          ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [NRAIL-1:0]  pg_in,
  output logic [NRAIL-1:0]  rail_en
);

  localparam int IW = (NRAIL > 1) ? $clog2(NRAIL) : 1;
  localparam int TW = 9 + $clog2(STEP_UNIT);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam logic [IW-1:0] LAST = IW'(NRAIL - 1);
  localparam logic [NRAIL-1:0] ALL_ON = {NRAIL{1'b1}};

  localparam logic [ADDR_W-1:0] A_VER  = ADDR_W'(4'h0);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(4'h6);
  localparam logic [ADDR_W-1:0] A_TMO  = ADDR_W'(4'h8);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(4'hA);
  localparam logic [ADDR_W-1:0] A_FAIL = ADDR_W'(4'hB);

  typedef enum logic [2:0] {S_OFF, S_RAMP, S_ON, S_DOWN, S_HOLD, S_FAULT} st_t;

  st_t              state;
  logic [IW-1:0]    idx;
  logic [TW-1:0]    tcnt;
  logic [HW-1:0]    hcnt;
  logic             ctrl_en;
  logic [7:0]       tmo_q;
  logic             alarm_q;
  logic [NRAIL-1:0] fail_q;

  logic [TW-1:0] limit, step_next;
  logic          expire;

  assign limit     = TW'(tmo_q) * TW'(STEP_UNIT);
  assign step_next = tcnt + TW'(1);
  assign expire    = step_next >= limit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_OFF;
      idx     <= '0;
      tcnt    <= '0;
      hcnt    <= '0;
      rail_en <= '0;
      alarm_q <= 1'b0;
      fail_q  <= '0;
      ctrl_en <= 1'b0;
      tmo_q   <= TMO_RESET;
    end else begin
      if (bus_wr && bus_addr == A_CTRL) ctrl_en <= bus_wdata[0];
      if (bus_wr && bus_addr == A_TMO)  tmo_q   <= bus_wdata;

      case (state)
        S_OFF: begin
          if (ctrl_en) begin
            state   <= S_RAMP;
            idx     <= '0;
            tcnt    <= '0;
            rail_en <= NRAIL'(1);
          end
        end
        S_RAMP: begin
          if (!ctrl_en) begin
            state <= S_DOWN;
          end else if (pg_in[idx]) begin
            tcnt <= '0;
            if (idx == LAST) begin
              state <= S_ON;
            end else begin
              idx     <= idx + IW'(1);
              rail_en <= rail_en | (NRAIL'(2) << idx);
            end
          end else if (expire) begin
            state   <= S_FAULT;
            alarm_q <= 1'b1;
            fail_q  <= NRAIL'(1) << idx;
            rail_en <= '0;
          end else begin
            tcnt <= step_next;
          end
        end
        S_ON: begin
          if (!ctrl_en) begin
            state <= S_DOWN;
            idx   <= LAST;
          end else if (pg_in != ALL_ON) begin
            state   <= S_FAULT;
            alarm_q <= 1'b1;
            fail_q  <= ~pg_in;
            rail_en <= '0;
          end
        end
        S_DOWN: begin
          rail_en <= rail_en & ~(NRAIL'(1) << idx);
          if (idx == '0) begin
            state <= S_HOLD;
            hcnt  <= '0;
          end else begin
            idx <= idx - IW'(1);
          end
        end
        S_HOLD: begin
          if (hcnt == HW'(HOLD_CYC - 1)) state <= S_OFF;
          else                           hcnt  <= hcnt + HW'(1);
        end
        S_FAULT: begin
          if (!ctrl_en) begin
            alarm_q <= 1'b0;
            fail_q  <= '0;
            state   <= S_HOLD;
            hcnt    <= '0;
          end
        end
        default: state <= S_OFF;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      A_VER:   bus_rdata = VERSION;
      A_CTRL:  bus_rdata = {7'd0, ctrl_en};
      A_TMO:   bus_rdata = tmo_q;
      A_STAT:  bus_rdata = 8'({alarm_q, pg_in});
      A_FAIL:  bus_rdata = 8'(fail_q);
      default: bus_rdata = 8'd0;
    endcase
  end

endmodule

// File: rtl/rail_sequencer_chk.sv
module rail_sequencer_chk #(
  parameter int NRAIL = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NRAIL-1:0] pg_in,
  input logic [NRAIL-1:0] rail_en,
  input logic             alarm,
  input logic [NRAIL-1:0] fail,
  input logic             ctrl_en
);

  // R2
  thermo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_en & NRAIL'(rail_en + NRAIL'(1))) == '0);

  // R2
  order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((rail_en & ~$past(rail_en)) >> 1) & ~$past(pg_in)) == '0);

  // R4
  fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |-> rail_en == '0);

  // R5
  fail_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail != '0) |-> alarm);

  // R6
  one_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm |-> $countones($past(rail_en) & ~rail_en) <= 1);

  // R7
  no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> (rail_en & ~$past(rail_en)) == '0);

endmodule

bind rail_sequencer rail_sequencer_chk #(.NRAIL(NRAIL)) chk_i (
  .clk(clk), .rst_n(rst_n), .pg_in(pg_in), .rail_en(rail_en),
  .alarm(alarm_q), .fail(fail_q), .ctrl_en(ctrl_en)
);

// File: tb/rail_sequencer_tb.sv
module rail_sequencer_tb_top;
  localparam int N = 4, SU = 4, HOLD = 20, DIS = 3;

  logic       clk = 0, rst_n = 0;
  logic [3:0] bus_addr = 0;
  logic       bus_wr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [3:0] pg = 0, rail_en;

  int ncmp = 0, nfail = 0;
  int dly[N] = '{3, 5, 2, 4};
  int oncnt[N] = '{0, 0, 0, 0};
  int offcnt[N] = '{DIS, DIS, DIS, DIS};
  bit dead[N] = '{0, 0, 0, 0};
  bit drop[N] = '{0, 0, 0, 0};

  int ms, mk, mt, mh, mr, ma, mf, mctl, mtmo;

  always #10 clk = ~clk;

  rail_sequencer #(.NRAIL(N), .STEP_UNIT(SU), .HOLD_CYC(HOLD),
    .TMO_RESET(8'd10), .VERSION(8'h03), .ADDR_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pg_in(pg), .rail_en(rail_en));

  always @(negedge clk) begin
    for (int k = 0; k < N; k++) begin
      if (rail_en[k]) begin
        offcnt[k] = 0;
        if (oncnt[k] < dly[k]) oncnt[k]++;
        pg[k] = !dead[k] && !drop[k] && oncnt[k] >= dly[k];
      end else begin
        oncnt[k] = 0;
        if (offcnt[k] < DIS) offcnt[k]++;
        if (offcnt[k] >= DIS) pg[k] = 1'b0;
      end
    end
  end

  always @(posedge clk) begin
    int octl;
    if (!rst_n) begin
      ms = 0; mk = 0; mt = 0; mh = 0; mr = 0; ma = 0; mf = 0; mctl = 0; mtmo = 10;
    end else begin
      octl = mctl;
      case (ms)
        0: if (octl != 0) begin ms = 1; mk = 0; mt = 0; mr = 1; end
        1: if (octl == 0) ms = 3;
           else if (pg[mk]) begin
             mt = 0;
             if (mk == N - 1) ms = 2;
             else begin mk++; mr = mr | (1 << mk); end
           end else if (mt + 1 >= mtmo * SU) begin
             ms = 5; ma = 1; mf = 1 << mk; mr = 0;
           end else mt++;
        2: if (octl == 0) begin ms = 3; mk = N - 1; end
           else if (pg != 4'hF) begin ms = 5; ma = 1; mf = int'(~pg); mr = 0; end
        3: begin
             mr = mr & ~(1 << mk);
             if (mk == 0) begin ms = 4; mh = 0; end else mk--;
           end
        4: if (mh == HOLD - 1) ms = 0; else mh++;
        5: if (octl == 0) begin ma = 0; mf = 0; ms = 4; mh = 0; end
        default: ms = 0;
      endcase
      if (bus_wr && bus_addr == 4'h6) mctl = int'(bus_wdata[0]);
      if (bus_wr && bus_addr == 4'h8) mtmo = int'(bus_wdata);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      ncmp++;
      if (rail_en !== 4'(mr)) begin
        nfail++;
        case (ms)
          1: $display("FAIL R2 rail_en actual %h expected %h", rail_en, mr);
          3: $display("FAIL R6 rail_en actual %h expected %h", rail_en, mr);
          4: $display("FAIL R7 rail_en actual %h expected %h", rail_en, mr);
          5: $display("FAIL R4 rail_en actual %h expected %h", rail_en, mr);
          default: $display("FAIL R2 rail_en actual %h expected %h", rail_en, mr);
        endcase
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); bus_addr = a; #5;
    ncmp++;
    if (bus_rdata !== exp) begin
      nfail++;
      $display("FAIL %s addr %h actual %h expected %h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    // R1 / R9 reset values and map
    rd(4'h0, 8'h03, "R1 version");
    rd(4'h6, 8'h00, "R1 control");
    rd(4'h8, 8'd10, "R1 timeout");
    rd(4'hA, 8'h00, "R1 status");
    rd(4'hB, 8'h00, "R1 fail");
    rd(4'h3, 8'h00, "R9 unmapped");
    // R2 / R3 normal bring-up
    wr(4'h6, 8'h01);
    idle(40);
    rd(4'hA, 8'h0F, "R3 all good");
    rd(4'h6, 8'h01, "R9 control readback");
    // R9 read-only registers
    wr(4'hA, 8'hFF); wr(4'hB, 8'hFF); wr(4'h0, 8'h00);
    rd(4'h0, 8'h03, "R9 version write ignored");
    rd(4'hB, 8'h00, "R9 fail write ignored");
    rd(4'hA, 8'h0F, "R9 status write ignored");
    // R6 / R7 quick toggle
    wr(4'h6, 8'h00);
    idle(2);
    wr(4'h6, 8'h01);
    idle(70);
    rd(4'hA, 8'h0F, "R7 restart after toggle");
    // R4 / R5 dead rail 2
    wr(4'h6, 8'h00);
    idle(40);
    dead[2] = 1;
    wr(4'h6, 8'h01);
    idle(80);
    rd(4'hB, 8'h04, "R4 fail rail");
    rd(4'hA, 8'h10, "R4 alarm status");
    idle(20);
    rd(4'hB, 8'h04, "R5 latched");
    wr(4'h6, 8'h00);
    idle(1);
    rd(4'hB, 8'h00, "R5 cleared fail");
    rd(4'hA, 8'h00, "R5 cleared alarm");
    dead[2] = 0;
    idle(30);
    // R8 loss while up
    wr(4'h6, 8'h01);
    idle(40);
    drop[1] = 1;
    idle(3);
    rd(4'hB, 8'h02, "R8 lost rail");
    wr(4'h6, 8'h00);
    drop[1] = 0;
    idle(30);
    // R10 abort during ramp
    dly[3] = 30;
    wr(4'h6, 8'h01);
    idle(15);
    wr(4'h6, 8'h00);
    idle(8);
    rd(4'hB, 8'h00, "R10 no alarm");
    rd(4'h6, 8'h00, "R10 control");
    dly[3] = 4;
    idle(30);
    // R11 zero timeout
    wr(4'h8, 8'h00);
    rd(4'h8, 8'h00, "R9 timeout write");
    wr(4'h6, 8'h01);
    idle(4);
    rd(4'hB, 8'h01, "R11 zero timeout");
    wr(4'h6, 8'h00);
    wr(4'h8, 8'd10);
    idle(30);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
    $finish;
  end

endmodule